// File: doc/BRIEF.md
# Dual-Master Hardware Semaphore Bank

This block is a bank of 2-bit ownership locks that two processors, master A and master B, use to share peripherals and general resources. Each lock reads as free, owned by A or owned by B. A lock that is occupied accepts nothing but a release, so whichever master claims a free lock first keeps it until a release arrives. Software claims a lock by writing its own code and then reading the lock back. The claim succeeded only if the read returns that code.

There is one lock each for the I2C controller, the SPI controller and the flash controller. A single word holds five independent GPIO-group locks, and a field written as 11 is left alone. Twelve general-purpose locks follow. Four read-only words report the locks: two pack the current codes and two pack the code each lock held just before its last release. Writes arrive on a simple strobed port that also carries a master-ID bit. Reads are addressed separately and return registered data.

Top module: `hw_sem_bank`

## Requirements
- R1: After a synchronous reset every lock, every previous-owner field and every status word reads as zero.
- R2: Lock codes are 00 free, 01 master A and 10 master B. A free lock takes the written 2-bit code wr_data[1:0] as-is. Word addresses are: 0 I2C lock, 1 SPI lock, 2 flash lock, 3 GPIO word, 4 to 15 general-purpose locks 1 to 12, 16 current-status word, 17 general-purpose status word, 18 peripheral previous-owner word, 19 general-purpose previous-owner word.
- R3: While a lock holds a nonzero code, any write other than 00 leaves it unchanged.
- R4: Writing 00 to an occupied lock frees it whatever the master-ID input says, and a write is applied whether or not the master-ID matches the written code.
- R5: The GPIO word holds five 2-bit locks at bits [1:0], [3:2], [5:4], [7:6] and [9:8], and each follows R2 and R3 on its own. Writing 11 to a field leaves that field unchanged.
- R6: Word 16 shows the I2C code at [1:0], the SPI code at [5:4], GPIO field 0 at [7:6] and the flash code at [9:8]. All other bits are zero.
- R7: Word 17 shows general-purpose locks 1 to 11 at two bits each, with lock n at [2n-1:2n-2]. Lock 12 does not appear, and the bits above are zero.
- R8: When a lock goes from nonzero to 00, its previous-owner field takes the released code. At no other time does the field change. Word 18 holds I2C at [1:0], SPI at [3:2], GPIO field 0 at [5:4], GPIO fields 1 to 4 at [9:8], [11:10], [13:12] and [15:14], and flash at [17:16].
- R9: Word 19 holds the previous owner of general-purpose lock n at [2n-1:2n-2], for n from 1 to 12.
- R10: rd_data shows the word addressed by rd_addr one clock edge later, and a read changes no state.
- R11: Writes to words 16 to 19 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Word address of the write |
| wr_data | input | 10 | Write data (the GPIO word uses all bits, single locks use [1:0]) |
| wr_master | input | 1 | ID of the writing master (0 = A, 1 = B); it does not affect the result |
| rd_addr | input | 5 | Word address of the read |
| rd_data | output | 32 | Registered read data |

## Verification
The hardest situations to reach are a previous-owner field that must hold still while its lock is claimed again, and a GPIO word write that claims one field, releases another and leaves the held fields untouched. The stimulus first runs claim/release cycles with different owners so that the previous-owner words contain distinct known codes. It then claims locks again and sends rejected writes, and checks that those words do not move. GPIO writes mix 11, 00 and owner codes in one word so that the keep, claim and hold rules all act in the same cycle.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef logic [1:0] code_t;

  localparam code_t CODE_FREE = 2'b00;
  localparam code_t CODE_A    = 2'b01;
  localparam code_t CODE_B    = 2'b10;
  localparam code_t CODE_KEEP = 2'b11;

  // Fixed word addresses of the single-lock registers; the rest derive from NGP.
  localparam int ADDR_I2C   = 0;
  localparam int ADDR_SPI   = 1;
  localparam int ADDR_FLASH = 2;
  localparam int ADDR_GPIO  = 3;
  localparam int ADDR_GP0   = 4;

  // Index of each peripheral lock inside the peripheral vector.
  localparam int PER_I2C   = 0;
  localparam int PER_SPI   = 1;
  localparam int PER_FLASH = 2;
  localparam int NPER      = 3;
endpackage

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
#(
  parameter bit KEEP_ON_ONES = 1'b0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_stb,
  input  code_t wr_code,
  output code_t cur,
  output code_t prv
);

  logic release_hit;
  assign release_hit = wr_stb && (cur != CODE_FREE) && (wr_code == CODE_FREE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= CODE_FREE;
      prv <= CODE_FREE;
    end else if (wr_stb) begin
      if (cur != CODE_FREE) begin
        if (wr_code == CODE_FREE) begin
          prv <= cur;
          cur <= CODE_FREE;
        end
      end else if (!(KEEP_ON_ONES && (wr_code == CODE_KEEP))) begin
        cur <= wr_code;
      end
    end
  end

  // R1: reset clears lock and history
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (cur == CODE_FREE) && (prv == CODE_FREE));

  // R3: an occupied lock holds unless a release arrives
  p_hold_busy_r3: assert property (@(posedge clk) disable iff (rst)
    ((cur != CODE_FREE) && !(wr_stb && (wr_code == CODE_FREE))) |=> (cur == $past(cur)));

  // R8: release moves the old code into history
  p_release_capture_r8: assert property (@(posedge clk) disable iff (rst)
    release_hit |=> (cur == CODE_FREE) && (prv == $past(cur)));

  // R8: history is stable except on a release
  p_prev_stable_r8: assert property (@(posedge clk) disable iff (rst)
    !release_hit |=> $stable(prv));

  generate
    if (KEEP_ON_ONES) begin : g_keep_chk
      // R5: a field written as 11 keeps its value
      p_keep_field_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && (wr_code == CODE_KEEP)) |=> $stable(cur));
    end
  endgenerate

endmodule

// File: rtl/sem_readmux.sv
module sem_readmux
  import sem_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int NGP    = 12,
  parameter int NGPIO  = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    rd_addr,
  input  logic [2*NPER-1:0]    per_cur,
  input  logic [2*NPER-1:0]    per_prv,
  input  logic [2*NGPIO-1:0]   gpio_cur,
  input  logic [2*NGPIO-1:0]   gpio_prv,
  input  logic [2*NGP-1:0]     gp_cur,
  input  logic [2*NGP-1:0]     gp_prv,
  output logic [DATA_W-1:0]    rd_data
);

  localparam int ADDR_STS_CUR = ADDR_GP0 + NGP;
  localparam int ADDR_STS_GP  = ADDR_STS_CUR + 1;
  localparam int ADDR_PRV_PER = ADDR_STS_CUR + 2;
  localparam int ADDR_PRV_GP  = ADDR_STS_CUR + 3;
  localparam int FLASH_PRV_LO = 2*NGPIO + 6;

  logic [DATA_W-1:0] sts_cur, sts_gp, prv_per, prv_gp, rd_next;

  always_comb begin
    sts_cur = '0;
    sts_cur[1:0] = per_cur[2*PER_I2C +: 2];
    sts_cur[5:4] = per_cur[2*PER_SPI +: 2];
    sts_cur[7:6] = gpio_cur[1:0];
    sts_cur[9:8] = per_cur[2*PER_FLASH +: 2];

    sts_gp = '0;
    for (int k = 0; k < NGP-1; k++) sts_gp[2*k +: 2] = gp_cur[2*k +: 2];

    prv_per = '0;
    prv_per[1:0] = per_prv[2*PER_I2C +: 2];
    prv_per[3:2] = per_prv[2*PER_SPI +: 2];
    prv_per[5:4] = gpio_prv[1:0];
    for (int k = 1; k < NGPIO; k++) prv_per[2*k+6 +: 2] = gpio_prv[2*k +: 2];
    prv_per[FLASH_PRV_LO +: 2] = per_prv[2*PER_FLASH +: 2];

    prv_gp = '0;
    prv_gp[2*NGP-1:0] = gp_prv;
  end

  always_comb begin
    rd_next = '0;
    if (rd_addr == ADDR_W'(ADDR_I2C))        rd_next[1:0] = per_cur[2*PER_I2C +: 2];
    else if (rd_addr == ADDR_W'(ADDR_SPI))   rd_next[1:0] = per_cur[2*PER_SPI +: 2];
    else if (rd_addr == ADDR_W'(ADDR_FLASH)) rd_next[1:0] = per_cur[2*PER_FLASH +: 2];
    else if (rd_addr == ADDR_W'(ADDR_GPIO))  rd_next[2*NGPIO-1:0] = gpio_cur;
    else if (rd_addr == ADDR_W'(ADDR_STS_CUR)) rd_next = sts_cur;
    else if (rd_addr == ADDR_W'(ADDR_STS_GP))  rd_next = sts_gp;
    else if (rd_addr == ADDR_W'(ADDR_PRV_PER)) rd_next = prv_per;
    else if (rd_addr == ADDR_W'(ADDR_PRV_GP))  rd_next = prv_gp;
    else begin
      for (int k = 0; k < NGP; k++)
        if (rd_addr == ADDR_W'(ADDR_GP0 + k)) rd_next[1:0] = gp_cur[2*k +: 2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  // R10: one-edge read latency on the I2C lock word
  p_read_latency_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == ADDR_W'(ADDR_I2C)) |=>
      (rd_data[1:0] == $past(per_cur[1:0])) && (rd_data[DATA_W-1:2] == '0));

endmodule

// File: rtl/hw_sem_bank.sv
module hw_sem_bank
  import sem_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int NGP    = 12,
  parameter int NGPIO  = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [2*NGPIO-1:0]   wr_data,
  input  logic                 wr_master,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data
);

  localparam int ADDR_STS_CUR = ADDR_GP0 + NGP;

  logic [2*NPER-1:0]  per_cur, per_prv;
  logic [2*NGPIO-1:0] gpio_cur, gpio_prv;
  logic [2*NGP-1:0]   gp_cur, gp_prv;

  generate
    for (genvar p = 0; p < NPER; p++) begin : g_per
      sem_cell #(.KEEP_ON_ONES(1'b0)) u_cell (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (wr_en && (wr_addr == ADDR_W'(ADDR_I2C + p))),
        .wr_code(wr_data[1:0]),
        .cur    (per_cur[2*p +: 2]),
        .prv    (per_prv[2*p +: 2])
      );
    end

    for (genvar g = 0; g < NGPIO; g++) begin : g_gpio
      sem_cell #(.KEEP_ON_ONES(1'b1)) u_cell (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (wr_en && (wr_addr == ADDR_W'(ADDR_GPIO))),
        .wr_code(wr_data[2*g +: 2]),
        .cur    (gpio_cur[2*g +: 2]),
        .prv    (gpio_prv[2*g +: 2])
      );
    end

    for (genvar n = 0; n < NGP; n++) begin : g_gp
      sem_cell #(.KEEP_ON_ONES(1'b0)) u_cell (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (wr_en && (wr_addr == ADDR_W'(ADDR_GP0 + n))),
        .wr_code(wr_data[1:0]),
        .cur    (gp_cur[2*n +: 2]),
        .prv    (gp_prv[2*n +: 2])
      );
    end
  endgenerate

  sem_readmux #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NGP(NGP), .NGPIO(NGPIO)
  ) u_rdmux (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (rd_addr),
    .per_cur (per_cur),
    .per_prv (per_prv),
    .gpio_cur(gpio_cur),
    .gpio_prv(gpio_prv),
    .gp_cur  (gp_cur),
    .gp_prv  (gp_prv),
    .rd_data (rd_data)
  );

  // R4: master B writing A's code into a free I2C lock is still applied
  p_any_master_claim_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_master && (wr_addr == ADDR_W'(ADDR_I2C)) && (wr_data[1:0] == CODE_A)
      && (per_cur[1:0] == CODE_FREE)) |=> (per_cur[1:0] == CODE_A));

  // R11: writes to the read-only words leave every lock alone
  p_ro_write_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr >= ADDR_W'(ADDR_STS_CUR))) |=>
      ($stable(per_cur) && $stable(gpio_cur) && $stable(gp_cur)));

endmodule

// File: tb/hw_sem_bank_tb_top.sv
`timescale 1ns/1ps
module hw_sem_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [9:0]  wr_data = '0;
  logic        wr_master = 1'b0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  hw_sem_bank dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_master(wr_master), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input int a, input logic [9:0] d, input logic m);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d; wr_master = m;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_addr = 5'(a);
    @(negedge clk);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s addr %0d actual 0x%08h expected 0x%08h", tag, a, rd_data, exp);
    end
  endtask

  task automatic t_reset();
    wr(0, 10'h1, 1'b0); wr(3, 10'h2AA, 1'b1); wr(4, 10'h1, 1'b0); wr(4, 10'h0, 1'b0);
    do_reset();
    for (int a = 0; a < 20; a++) chk(a, 32'h0, "R1 reset");
  endtask

  task automatic t_claim();
    do_reset();
    wr(0, 10'h1, 1'b0);  chk(0, 32'h1, "R2 claim I2C by A");
    wr(2, 10'h2, 1'b1);  chk(2, 32'h2, "R2 claim flash by B");
    wr(15, 10'h2, 1'b1); chk(15, 32'h2, "R2 claim GP lock 12");
    wr(1, 10'h3, 1'b0);  chk(1, 32'h3, "R2 free lock takes 11");
  endtask

  task automatic t_hold();
    do_reset();
    wr(0, 10'h1, 1'b0);
    wr(0, 10'h2, 1'b1); chk(0, 32'h1, "R3 reject 10 on held lock");
    wr(0, 10'h3, 1'b1); chk(0, 32'h1, "R3 reject 11 on held lock");
    wr(9, 10'h2, 1'b1); wr(9, 10'h1, 1'b0); chk(9, 32'h2, "R3 GP lock holds");
  endtask

  task automatic t_release_any();
    do_reset();
    wr(0, 10'h1, 1'b0);
    wr(0, 10'h0, 1'b1); chk(0, 32'h0, "R4 release by other master");
    wr(0, 10'h2, 1'b1); chk(0, 32'h2, "R4 reclaim after release");
    wr(1, 10'h1, 1'b1); chk(1, 32'h1, "R4 mismatched master ID applied");
  endtask

  task automatic t_gpio();
    do_reset();
    wr(3, 10'h3FB, 1'b1); chk(3, 32'h008, "R5 claim group 1 only");
    wr(3, 10'h3FD, 1'b0); chk(3, 32'h009, "R5 claim group 0, keep group 1");
    wr(3, 10'h3FE, 1'b1); chk(3, 32'h009, "R5 held field rejects other code");
    wr(3, 10'h3F3, 1'b1); chk(3, 32'h001, "R5 release group 1 only");
    wr(3, 10'h000, 1'b0); chk(3, 32'h000, "R5 release all");
  endtask

  task automatic t_status();
    do_reset();
    wr(0, 10'h1, 1'b0); wr(1, 10'h2, 1'b1); wr(2, 10'h1, 1'b0);
    wr(3, 10'h3FE, 1'b1); wr(3, 10'h3F7, 1'b0);
    chk(16, 32'h1A1, "R6 current status word");
    wr(4, 10'h1, 1'b0); wr(14, 10'h2, 1'b1); wr(15, 10'h1, 1'b0);
    chk(17, 32'h200001, "R7 GP status, lock 12 hidden");
  endtask

  task automatic t_prev();
    do_reset();
    wr(0, 10'h1, 1'b0);
    chk(18, 32'h0, "R8 history unchanged while held");
    wr(0, 10'h0, 1'b0);
    wr(1, 10'h2, 1'b1); wr(1, 10'h0, 1'b1);
    wr(3, 10'h3FD, 1'b0); wr(3, 10'h3FC, 1'b0);
    wr(3, 10'h2FF, 1'b1); wr(3, 10'h0FF, 1'b1);
    wr(2, 10'h2, 1'b1); wr(2, 10'h0, 1'b1);
    chk(18, 32'h28019, "R8 peripheral history word");
    wr(0, 10'h2, 1'b1); wr(0, 10'h1, 1'b0);
    chk(18, 32'h28019, "R8 history stable on reclaim and reject");
    wr(15, 10'h1, 1'b0); wr(15, 10'h0, 1'b0);
    wr(4, 10'h2, 1'b1);  wr(4, 10'h0, 1'b1);
    chk(19, 32'h400002, "R9 GP history word");
  endtask

  task automatic t_readonly();
    do_reset();
    wr(6, 10'h2, 1'b1);
    for (int a = 16; a < 20; a++) wr(a, 10'h3FF, 1'b0);
    chk(16, 32'h0, "R11 status word not writable");
    chk(18, 32'h0, "R11 history word not writable");
    chk(17, 32'h20, "R11 GP status intact");
    chk(6, 32'h2, "R10 first read");
    chk(6, 32'h2, "R10 repeated read has no side effect");
    chk(0, 32'h0, "R10 read of other word");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_claim();
    t_hold();
    t_release_any();
    t_gpio();
    t_status();
    t_prev();
    t_readonly();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule